// File: doc/BRIEF.md
# H-Bridge Drive Controller with Delayed Fault Latch

This block is the digital control core of a two-leg H-bridge motor driver. Two direction inputs select one of four modes: inhibit (all transistors off, both outputs floating), drive in either direction, and brake (both high sides on). The block turns these into four gate enables, one high-side and one low-side per leg. It never lets both transistors of one leg conduct at once, and it holds a leg fully off for a programmable dead time whenever that leg changes from one conducting state to the other.

Status inputs come from analog comparators outside the block: a high-side short to ground per leg, a low-side overcurrent per leg, over-temperature and supply undervoltage. A short or an overcurrent only counts as a fault while the transistor it belongs to is enabled. It must stay present for a fixed delay, counted in clock cycles from a clock-frequency parameter, before the block latches a full shutdown and pulls the active-low error flag. Over-temperature skips that delay. Undervoltage removes every enable at once but does not touch the flag. Once latched, a fault clears only when the synchronized command changes.

Top module: `hbridge_ctl`

## Requirements
- R1: With command {dir_b,dir_a} = 2'b00 (inhibit), hs_en and ls_en are both 2'b00.
- R2: Command 2'b10 drives leg 0 low and leg 1 high (hs_en = 2'b10, ls_en = 2'b01). Command 2'b01 drives leg 0 high and leg 1 low (hs_en = 2'b01, ls_en = 2'b10). Bit i of each enable bus belongs to leg i.
- R3: Command 2'b11 (brake) gives hs_en = 2'b11 and ls_en = 2'b00.
- R4: A qualifying fault (hs_short[i] while hs_en[i] is high, or ls_overcur[i] while ls_en[i] is high) that is present at FAULT_CYC = (CLK_HZ/1e6)*FAULT_US consecutive rising edges drives err_n low on the last of those edges. From then on all enables are off, and the latch holds after the fault input goes away.
- R5: One edge without a qualifying fault restarts the delay count from zero. A short or overcurrent flag on a transistor that is not enabled is ignored.
- R6: over_temp sampled high at a rising edge drives err_n low and all enables off after that same edge.
- R7: A change of the command clears the latch at the third rising edge after the input change. The latch does not clear while over_temp is still high.
- R8: under_volt high forces all four enables low in the same cycle, without a clock edge, and never drives err_n low. The enables come back when it drops.
- R9: hs_en[i] and ls_en[i] are never high together. When a leg switches between its high and low state, both of its enables stay low for exactly DEAD_CYC+1 cycles.
- R10: A command change reaches the enables at the third rising edge after the input changes (two synchronizer stages plus the leg state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input A, asynchronous |
| dir_b | input | 1 | Direction input B, asynchronous |
| hs_short | input | 2 | Per-leg high-side short-to-ground comparator |
| ls_overcur | input | 2 | Per-leg low-side overcurrent comparator |
| over_temp | input | 1 | Over-temperature flag |
| under_volt | input | 1 | Supply undervoltage flag |
| hs_en | output | 2 | High-side gate enable per leg |
| ls_en | output | 2 | Low-side gate enable per leg |
| err_n | output | 1 | Error flag, active low |

## Verification
The bench steps through all sixteen ordered pairs of commands and counts, per leg, the cycles in which both enables are off. A design that skipped the dead time, or took the wrong path from inhibit, would give a different count or would overlap the two enables of a leg. The fault delay is checked one edge before and at the edge where it expires, so a counter that is off by one fails. A gap of one cycle placed just before expiry shows whether the count restarts, and flags on transistors that are off are held for twice the delay to show they do not count. Over-temperature is checked for its one-edge response, for the latch that stays after it drops, and for the latch that holds when the command changes while it is still high. Undervoltage is checked for an immediate cut-off with the flag left alone.

// File: rtl/hbridge_ctl.sv
module hbridge_ctl #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int FAULT_US = 40,
  parameter int DEAD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_a,
  input  logic       dir_b,
  input  logic [1:0] hs_short,
  input  logic [1:0] ls_overcur,
  input  logic       over_temp,
  input  logic       under_volt,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output logic       err_n
);
  localparam int FAULT_CYC = (CLK_HZ / 1_000_000) * FAULT_US;
  localparam int FCW = $clog2(FAULT_CYC + 1);
  localparam int DTW = $clog2(DEAD_CYC + 2);
  localparam logic [FCW-1:0] FLAST = FCW'(FAULT_CYC - 1);

  typedef enum logic [1:0] {LEG_OFF = 2'd0, LEG_HI = 2'd1, LEG_LO = 2'd2} leg_t;

  logic [1:0] cmd_s1, cmd_s2, cmd_q;
  logic [1:0] qual;
  logic [FCW-1:0] fcnt;
  logic flt;
  logic run;
  leg_t want [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_s1 <= 2'b00;
      cmd_s2 <= 2'b00;
      cmd_q  <= 2'b00;
    end else begin
      cmd_s1 <= {dir_b, dir_a};
      cmd_s2 <= cmd_s1;
      cmd_q  <= cmd_s2;
    end

  always_comb begin
    want[0] = LEG_OFF;
    want[1] = LEG_OFF;
    case (cmd_s2)
      2'b01: begin want[0] = LEG_HI; want[1] = LEG_LO; end
      2'b10: begin want[0] = LEG_LO; want[1] = LEG_HI; end
      2'b11: begin want[0] = LEG_HI; want[1] = LEG_HI; end
      default: ;
    endcase
  end

  assign run = !flt && !under_volt;

  for (genvar g = 0; g < 2; g++) begin : g_leg
    leg_t cur;
    logic [DTW-1:0] dt;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cur <= LEG_OFF;
        dt  <= '0;
      end else if (cur != want[g]) begin
        if (cur != LEG_OFF) begin
          cur <= LEG_OFF;
          dt  <= DTW'(DEAD_CYC);
        end else if (dt == '0) cur <= want[g];
        else dt <= dt - DTW'(1);
      end else if (dt != '0) dt <= dt - DTW'(1);

    assign hs_en[g] = run && (cur == LEG_HI);
    assign ls_en[g] = run && (cur == LEG_LO);
    assign qual[g]  = (hs_short[g] && hs_en[g]) || (ls_overcur[g] && ls_en[g]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt  <= 1'b0;
      fcnt <= '0;
    end else begin
      if (over_temp || ((|qual) && fcnt == FLAST)) flt <= 1'b1;
      else if (cmd_s2 != cmd_q) flt <= 1'b0;
      if (!(|qual) || flt) fcnt <= '0;
      else if (fcnt != FLAST) fcnt <= fcnt + FCW'(1);
    end

  assign err_n = !flt;
endmodule

// File: rtl/hbridge_ctl_chk.sv
module hbridge_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       over_temp,
  input logic       under_volt,
  input logic [1:0] hs_en,
  input logic [1:0] ls_en,
  input logic       err_n
);
  for (genvar g = 0; g < 2; g++) begin : g_leg
    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[g] && ls_en[g])); // R9
    AST_HS_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_en[g]) |=> !ls_en[g]); // R9
    AST_LS_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ls_en[g]) |=> !hs_en[g]); // R9
  end

  AST_UV_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    under_volt |-> (hs_en == 2'b00 && ls_en == 2'b00)); // R8
  AST_OT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> !err_n); // R6
  AST_FLAG_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> (hs_en == 2'b00 && ls_en == 2'b00)); // R4
endmodule

bind hbridge_ctl hbridge_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .over_temp (over_temp),
  .under_volt(under_volt),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .err_n     (err_n)
);

// File: tb/hbridge_ctl_bench.sv
module hbridge_ctl_bench;
  localparam int DLY  = 40;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0;
  logic [1:0] hs_short = 2'b00, ls_overcur = 2'b00;
  logic over_temp = 1'b0, under_volt = 1'b0;
  logic [1:0] hs_en, ls_en;
  logic err_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hbridge_ctl #(.CLK_HZ(1_000_000), .FAULT_US(40), .DEAD_CYC(DEAD)) u_hbridge_ctl (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
    .hs_short(hs_short), .ls_overcur(ls_overcur),
    .over_temp(over_temp), .under_volt(under_volt),
    .hs_en(hs_en), .ls_en(ls_en), .err_n(err_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 off, 1 high, 2 low; code = {dir_b, dir_a}
  function automatic int leg_of(input int code, input int leg);
    case (code)
      1: return (leg == 0) ? 1 : 2;
      2: return (leg == 0) ? 2 : 1;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_off(input int o, input int n);
    if (o == n) return (o == 0) ? 12 : 0;
    if (o == 0) return 2;
    if (n == 0) return 10;
    return DEAD + 1;
  endfunction

  task automatic set_cmd(input int c);
    @(negedge clk);
    {dir_b, dir_a} = c[1:0];
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk("R1 reset hs_en", hs_en, 0);
    chk("R1 reset ls_en", ls_en, 0);
    chk("R4 reset err_n", err_n, 1);
    @(negedge clk); rst_n = 1'b1;

    // R10 latency from inhibit to drive
    set_cmd(1);
    edges(2);
    chk("R10 before third edge hs_en", hs_en, 0);
    edges(1);
    chk("R10 third edge hs_en", hs_en, 1);
    chk("R10 third edge ls_en", ls_en, 2);

    // R1 R2 R3 R9 sweep of every command transition
    for (int fr = 0; fr < 4; fr++) begin
      for (int to = 0; to < 4; to++) begin
        int off0, off1;
        bit ovl;
        string tg;
        set_cmd(fr);
        repeat (12) @(posedge clk);
        set_cmd(to);
        off0 = 0; off1 = 0; ovl = 1'b0;
        for (int s = 0; s < 12; s++) begin
          edges(1);
          if (!hs_en[0] && !ls_en[0]) off0++;
          if (!hs_en[1] && !ls_en[1]) off1++;
          if ((hs_en & ls_en) != 2'b00) ovl = 1'b1;
        end
        tg = (to == 0) ? "R1" : (to == 3) ? "R3" : "R2";
        chk($sformatf("R9 leg0 off cycles %0d->%0d", fr, to), off0, exp_off(leg_of(fr, 0), leg_of(to, 0)));
        chk($sformatf("R9 leg1 off cycles %0d->%0d", fr, to), off1, exp_off(leg_of(fr, 1), leg_of(to, 1)));
        chk($sformatf("R9 overlap %0d->%0d", fr, to), ovl, 0);
        chk($sformatf("%s hs_en code %0d", tg, to), hs_en,
            {30'd0, leg_of(to, 1) == 1, leg_of(to, 0) == 1});
        chk($sformatf("%s ls_en code %0d", tg, to), ls_en,
            {30'd0, leg_of(to, 1) == 2, leg_of(to, 0) == 2});
      end
    end

    // R6 R7 over-temperature
    set_cmd(1); repeat (12) @(posedge clk);
    @(negedge clk); over_temp = 1'b1;
    edges(1);
    chk("R6 err_n after one edge", err_n, 0);
    chk("R6 hs_en off", hs_en, 0);
    chk("R6 ls_en off", ls_en, 0);
    @(negedge clk); over_temp = 1'b0;
    edges(5);
    chk("R7 latch held after removal", err_n, 0);
    set_cmd(3);
    edges(2);
    chk("R7 not cleared before third edge", err_n, 0);
    edges(1);
    chk("R7 cleared at third edge", err_n, 1);
    @(negedge clk); over_temp = 1'b1;
    set_cmd(1);
    edges(4);
    chk("R7 held while over_temp high", err_n, 0);
    @(negedge clk); over_temp = 1'b0;
    set_cmd(3); edges(3);
    chk("R7 cleared after over_temp drop", err_n, 1);

    // R4 short on the enabled high side of leg 0
    set_cmd(1); repeat (12) @(posedge clk);
    @(negedge clk); hs_short = 2'b01;
    edges(DLY - 1);
    chk("R4 no flag before delay", err_n, 1);
    chk("R4 drive kept before delay", hs_en, 1);
    edges(1);
    chk("R4 flag at delay", err_n, 0);
    chk("R4 hs_en off at delay", hs_en, 0);
    chk("R4 ls_en off at delay", ls_en, 0);
    @(negedge clk); hs_short = 2'b00;
    edges(3);
    chk("R4 latch holds", err_n, 0);
    set_cmd(3); edges(3);
    chk("R7 cleared after short", err_n, 1);

    // R5 restart of the delay count
    set_cmd(1); repeat (12) @(posedge clk);
    @(negedge clk); hs_short = 2'b01;
    repeat (DLY - 5) @(posedge clk);
    @(negedge clk); hs_short = 2'b00;
    @(posedge clk);
    @(negedge clk); hs_short = 2'b01;
    edges(DLY - 1);
    chk("R5 count restarted", err_n, 1);
    edges(1);
    chk("R5 flag after full run", err_n, 0);
    @(negedge clk); hs_short = 2'b00;
    set_cmd(3); edges(3);
    set_cmd(1); repeat (12) @(posedge clk);

    // R5 flags on disabled transistors are ignored
    @(negedge clk); hs_short = 2'b10; ls_overcur = 2'b01;
    edges(2 * DLY);
    chk("R5 ignored flags err_n", err_n, 1);
    chk("R5 ignored flags hs_en", hs_en, 1);
    chk("R5 ignored flags ls_en", ls_en, 2);
    @(negedge clk); hs_short = 2'b00; ls_overcur = 2'b00;

    // R4 low-side overcurrent on leg 1
    @(negedge clk); ls_overcur = 2'b10;
    edges(DLY - 1);
    chk("R4 overcurrent before delay", err_n, 1);
    edges(1);
    chk("R4 overcurrent at delay", err_n, 0);
    @(negedge clk); ls_overcur = 2'b00;
    set_cmd(2); edges(3);
    chk("R7 cleared after overcurrent", err_n, 1);

    // R8 undervoltage
    repeat (12) @(posedge clk);
    @(negedge clk); under_volt = 1'b1;
    #1;
    chk("R8 hs_en cut", hs_en, 0);
    chk("R8 ls_en cut", ls_en, 0);
    edges(DLY + 5);
    chk("R8 no flag", err_n, 1);
    @(negedge clk); under_volt = 1'b0;
    #1;
    chk("R8 hs_en restored", hs_en, 2);
    chk("R8 ls_en restored", ls_en, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule